// File: doc/BRIEF.md
# Table-Mapped 64-Source Interrupt Controller

This block gathers up to 64 interrupt sources into two 32-bit pending words, one high and one low. A matching pair of mask words selects which sources may interrupt the processor. Each source number reaches its word and bit through a fixed, non-arithmetic placement rule. Source events arrive already conditioned, as one-cycle pulses on `src_evt`. Software uses a small register bus with combinational reads and clocked writes.

Software enables sources by writing mask words and acknowledges sources by writing ones into a pending word. It learns the active source by reading the vector word. The source number sits in the six top bits of that word, and zero there means that nothing is active. When several enabled sources are pending, the lowest-numbered one is reported. A single request line, `cpu_irq`, is high while any pending bit is also enabled.

Top module: `ic64_ctrl`

## Requirements
- R1: Placement rule. Sources 0–15 and 32–47 live in the low word. Sources 16–31 and 48–63 live in the high word. Bit positions are as follows:
  - source 0 uses bit 0;
  - source n from 1 to 15 uses bit 16−n;
  - sources 16, 17 and 18 use bits 2, 1 and 0;
  - source n from 19 to 30 uses bit 33−n;
  - source 31 uses bit 0, which it shares with source 18;
  - source n from 32 to 47 uses bit 63−n;
  - source n from 48 to 63 uses bit n−32.

  Bit 15 of the high word is never set.
- R2: The mask words are read/write. Address 0 holds the high mask and address 1 holds the low mask. A mask bit of 1 enables its source and 0 blocks it. A written value appears from the next clock edge. A mask word changes only when it is written.
- R3: A pulse on `src_evt[n]` sets the pending bit that R1 gives for source n, from the next clock edge. Address 2 reads the high pending word and address 3 reads the low pending word. Pending bits are set whether or not the source is masked.
- R4: A write to a pending word clears every bit written as 1 and leaves every bit written as 0 unchanged. Writing all ones to both pending words empties them. A pending write never sets a bit.
- R5: Address 4 reads the vector word. Bits 31:26 hold the lowest-numbered source from 1 to 63 that is both pending and enabled, or 0 if there is none. Bits 25:0 read 0. Source 0 is never reported. Writes to address 4 are ignored, and reading it changes no state.
- R6: `cpu_irq` is 1 exactly when some pending bit has its mask bit at 1. This includes source 0.
- R7: Synchronous active-high reset clears both mask words and both pending words. Addresses 5 to 7 read 0, and writes to them have no effect.
- R8: Suppose a source event and a software clear hit the same pending bit in the same cycle. The bit is set after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | 64 | One-cycle event pulse per source number |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The hardest situations to reach from the ports are two collisions.

The first is an event landing in the very cycle that software clears the same pending bit. The stimulus reaches it by driving the event and a write-one-to-clear on one edge. It then reads the pending word afterward.

The second is the shared high bit 0. The stimulus pulses source 18 and source 31 separately and checks that both land on that bit. It also checks that the vector reports 18 when this bit is enabled. A long random phase adds sparse events, mask writes and clears, and it compares every read and the request line with a behavioural model on each cycle.

// File: rtl/ic_pkg.sv
package ic_pkg;
    localparam int NUM_SRC   = 64;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 2;
    localparam int SRC_IDX_W = $clog2(NUM_SRC);
    localparam int BIT_IDX_W = $clog2(WORD_W);
    localparam int ADDR_W    = 3;
    localparam int VEC_LSB   = WORD_W - SRC_IDX_W;

    // word index 0 is the high word, 1 the low word
    localparam int WORD_HI = 0;
    localparam int WORD_LO = 1;

    typedef enum logic [ADDR_W-1:0] {
        REG_MASK_HI = 3'd0,
        REG_MASK_LO = 3'd1,
        REG_PEND_HI = 3'd2,
        REG_PEND_LO = 3'd3,
        REG_VEC     = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic                 word;
        logic [BIT_IDX_W-1:0] bitpos;
    } src_loc_t;

    typedef logic [NUM_WORDS-1:0][WORD_W-1:0] word_pair_t;

    // fixed placement of a source number on a word and bit
    function automatic src_loc_t src_locate(input logic [SRC_IDX_W-1:0] n);
        src_loc_t             loc;
        logic [BIT_IDX_W-1:0] low5;
        low5 = n[BIT_IDX_W-1:0];
        loc.word = ~n[4];
        case (n[5:4])
            2'd0:    loc.bitpos = (low5 == 5'd0) ? 5'd0 : 5'd16 - low5;
            2'd1: begin
                if (low5 < 5'd19)
                    loc.bitpos = 5'd18 - low5;
                else if (low5 == 5'd31)
                    loc.bitpos = 5'd0;
                else
                    loc.bitpos = 5'd1 - low5;   // 33 - n modulo 32
            end
            2'd2:    loc.bitpos = 5'd31 - low5;
            default: loc.bitpos = low5;
        endcase
        return loc;
    endfunction
endpackage

// File: rtl/ic_map_decode.sv
module ic_map_decode
    import ic_pkg::*;
(
    input  logic [NUM_SRC-1:0] evt,
    output word_pair_t         set_bits
);
    always_comb begin
        set_bits = '0;
        for (int n = 0; n < NUM_SRC; n++) begin
            src_loc_t loc;
            loc = src_locate(SRC_IDX_W'(n));
            if (evt[n])
                set_bits[loc.word][loc.bitpos] = 1'b1;
        end
    end
endmodule

// File: rtl/ic_word_bank.sv
module ic_word_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mask_we,
    input  logic         pend_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] set_bits,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] pend_q
);
    logic [W-1:0] clr_bits;
    assign clr_bits = pend_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            pend_q <= '0;
        end else begin
            if (mask_we)
                mask_q <= wdata;
            pend_q <= (pend_q & ~clr_bits) | set_bits;
        end
    end

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> (mask_q == $past(wdata)));                           // R2
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mask_we |=> $stable(mask_q));                                   // R2
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        pend_we |=> ((pend_q & $past(wdata & ~set_bits)) == '0));        // R4
    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
        pend_we |=> ((pend_q & $past(pend_q & ~wdata)) == $past(pend_q & ~wdata))); // R4
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        (|set_bits) |=> ((pend_q & $past(set_bits)) == $past(set_bits))); // R8
endmodule

// File: rtl/ic_vec_encode.sv
module ic_vec_encode
    import ic_pkg::*;
(
    input  word_pair_t           pend,
    input  word_pair_t           mask,
    output logic [SRC_IDX_W-1:0] vec_num,
    output logic                 any_active
);
    word_pair_t active;

    always_comb begin
        active     = pend & mask;
        any_active = |active;
        vec_num    = '0;
        // walk downward so the lowest-numbered active source is kept
        for (int n = NUM_SRC - 1; n >= 1; n--) begin
            src_loc_t loc;
            loc = src_locate(SRC_IDX_W'(n));
            if (active[loc.word][loc.bitpos])
                vec_num = SRC_IDX_W'(n);
        end
    end
endmodule

// File: rtl/ic64_ctrl.sv
module ic64_ctrl
    import ic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   src_evt,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic                 cpu_irq
);
    word_pair_t           set_bits;
    word_pair_t           mask_q;
    word_pair_t           pend_q;
    logic [SRC_IDX_W-1:0] vec_num;
    logic                 any_active;

    ic_map_decode u_map (
        .evt      (src_evt),
        .set_bits (set_bits)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam logic [ADDR_W-1:0] MASK_ADDR = (w == WORD_HI) ? REG_MASK_HI : REG_MASK_LO;
        localparam logic [ADDR_W-1:0] PEND_ADDR = (w == WORD_HI) ? REG_PEND_HI : REG_PEND_LO;
        ic_word_bank #(.W(WORD_W)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .mask_we  (bus_we && (bus_addr == MASK_ADDR)),
            .pend_we  (bus_we && (bus_addr == PEND_ADDR)),
            .wdata    (bus_wdata),
            .set_bits (set_bits[w]),
            .mask_q   (mask_q[w]),
            .pend_q   (pend_q[w])
        );
    end

    ic_vec_encode u_enc (
        .pend       (pend_q),
        .mask       (mask_q),
        .vec_num    (vec_num),
        .any_active (any_active)
    );

    assign cpu_irq = any_active;

    always_comb begin
        case (bus_addr)
            REG_MASK_HI: bus_rdata = mask_q[WORD_HI];
            REG_MASK_LO: bus_rdata = mask_q[WORD_LO];
            REG_PEND_HI: bus_rdata = pend_q[WORD_HI];
            REG_PEND_LO: bus_rdata = pend_q[WORD_LO];
            REG_VEC:     bus_rdata = {vec_num, {VEC_LSB{1'b0}}};
            default:     bus_rdata = '0;
        endcase
    end

    AST_HI15_IDLE: assert property (@(posedge clk) disable iff (rst)
        !pend_q[WORD_HI][15]);                                           // R1
    AST_VEC_NEEDS_IRQ: assert property (@(posedge clk) disable iff (rst)
        ((bus_addr == REG_VEC) && (bus_rdata != '0)) |-> cpu_irq);       // R5
    AST_VEC_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == REG_VEC) |-> (bus_rdata[VEC_LSB-1:0] == '0));       // R5
endmodule

// File: tb/ic64_ctrl_test.sv
`timescale 1ns/1ps
module ic64_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src_evt = '0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state: index 0 high word, 1 low word
    logic [31:0] m_mask [2];
    logic [31:0] m_pend [2];

    always #4 clk = ~clk;

    ic64_ctrl uut (
        .clk(clk), .rst(rst), .src_evt(src_evt), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    function automatic int m_word(int n);
        return (((n / 16) % 2) == 1) ? 0 : 1;
    endfunction

    function automatic int m_bit(int n);
        if (n == 0)       return 0;
        else if (n < 16)  return 16 - n;
        else if (n < 19)  return 18 - n;
        else if (n < 31)  return 33 - n;
        else if (n == 31) return 0;
        else if (n < 48)  return 63 - n;
        else              return n - 32;
    endfunction

    function automatic logic [31:0] m_read(logic [2:0] a);
        logic [31:0] r;
        r = '0;
        case (a)
            3'd0: r = m_mask[0];
            3'd1: r = m_mask[1];
            3'd2: r = m_pend[0];
            3'd3: r = m_pend[1];
            3'd4: begin
                for (int n = 63; n >= 1; n--)
                    if (m_pend[m_word(n)][m_bit(n)] && m_mask[m_word(n)][m_bit(n)])
                        r = 32'(n) << 26;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic m_irq();
        return ((m_pend[0] & m_mask[0]) != 0) || ((m_pend[1] & m_mask[1]) != 0);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string addr_tag(logic [2:0] a);
        if (a <= 3'd1) return "R2 mask read";
        if (a <= 3'd3) return "R3 pending read";
        if (a == 3'd4) return "R5 vector read";
        return "R7 unmapped read";
    endfunction

    // one cycle: drive, compare outputs against the model, clock, update model
    task automatic step(logic we, logic [2:0] a, logic [31:0] d, logic [63:0] ev);
        logic [31:0] setv [2];
        logic [31:0] clr;
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; src_evt = ev;
        #1;
        chk(addr_tag(a), bus_rdata, m_read(a));
        chk("R6 irq", {31'b0, cpu_irq}, {31'b0, m_irq()});
        @(posedge clk);
        setv[0] = '0; setv[1] = '0;
        for (int n = 0; n < 64; n++)
            if (ev[n]) setv[m_word(n)][m_bit(n)] = 1'b1;
        for (int w = 0; w < 2; w++) begin
            if (we && a == 3'(w)) m_mask[w] = d;
            clr = (we && a == 3'(2 + w)) ? d : '0;
            m_pend[w] = (m_pend[w] & ~clr) | setv[w];
        end
    endtask

    task automatic peek(logic [2:0] a, string tag, logic [31:0] exp);
        step(1'b0, a, '0, '0);
        chk(tag, bus_rdata, exp);
    endtask

    task automatic clear_all();
        step(1'b1, 3'd2, 32'hffff_ffff, '0);
        step(1'b1, 3'd3, 32'hffff_ffff, '0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        m_mask[0] = '0; m_mask[1] = '0; m_pend[0] = '0; m_pend[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R7 reset state
        for (int a = 0; a < 8; a++) peek(3'(a), "R7 reset state", 32'h0);
        chk("R7 irq after reset", {31'b0, cpu_irq}, 32'h0);

        // R1 explicit placements
        step(1'b0, 3'd0, '0, 64'h1 << 1);  peek(3'd3, "R1 source 1", 32'h0000_8000); clear_all();
        step(1'b0, 3'd0, '0, 64'h1 << 48); peek(3'd2, "R1 source 48", 32'h0001_0000); clear_all();
        step(1'b0, 3'd0, '0, 64'h1 << 63); peek(3'd2, "R1 source 63", 32'h8000_0000); clear_all();
        step(1'b0, 3'd0, '0, 64'h1 << 31); peek(3'd2, "R1 source 31", 32'h0000_0001); clear_all();
        step(1'b0, 3'd0, '0, 64'h1 << 19); peek(3'd2, "R1 source 19", 32'h0000_4000); clear_all();
        step(1'b0, 3'd0, '0, 64'h1 << 32); peek(3'd3, "R1 source 32", 32'h8000_0000); clear_all();
        // R1 every source, both words
        for (int n = 0; n < 64; n++) begin
            step(1'b0, 3'd0, '0, 64'h1 << n);
            peek(3'(2 + m_word(n)), "R1 sweep", 32'h1 << m_bit(n));
            peek(3'(3 - m_word(n)), "R1 sweep other word", 32'h0);
            clear_all();
        end

        // R3 masked source still pends, R6 irq low while masked
        step(1'b0, 3'd0, '0, 64'h1 << 5);
        peek(3'd3, "R3 masked pend", 32'h0000_0800);
        chk("R6 masked no irq", {31'b0, cpu_irq}, 32'h0);
        // R2 mask write and readback
        step(1'b1, 3'd1, 32'h0000_0800, '0);
        peek(3'd1, "R2 mask low", 32'h0000_0800);
        chk("R6 enabled irq", {31'b0, cpu_irq}, 32'h1);
        // R5 priority: source 5 and 40 pending, both enabled
        step(1'b1, 3'd1, 32'hffff_ffff, 64'h1 << 40);
        peek(3'd4, "R5 lowest wins", 32'h1400_0000);
        // R5 write to vector ignored, reads are harmless
        step(1'b1, 3'd4, 32'hffff_ffff, '0);
        for (int k = 0; k < 4; k++) peek(3'd4, "R5 repeated read", 32'h1400_0000);
        peek(3'd3, "R5 read no side effect", 32'h0080_0800);
        // R4 zero bits keep, one bits clear
        step(1'b1, 3'd3, 32'h0000_0800, '0);
        peek(3'd3, "R4 partial clear", 32'h0080_0000);
        peek(3'd4, "R5 next source", 32'(40) << 26);
        step(1'b1, 3'd3, 32'h0, '0);
        peek(3'd3, "R4 zero write keeps", 32'h0080_0000);
        // R8 event wins over same-cycle clear
        step(1'b1, 3'd3, 32'h0080_0000, 64'h1 << 40);
        peek(3'd3, "R8 event beats clear", 32'h0080_0000);
        // R5 source 0 never reported, R6 still requests
        clear_all();
        step(1'b0, 3'd0, '0, 64'h1);
        peek(3'd4, "R5 source 0 hidden", 32'h0);
        chk("R6 source 0 irq", {31'b0, cpu_irq}, 32'h1);
        // shared bit: source 18 reported
        step(1'b1, 3'd0, 32'h0000_0001, 64'h1 << 31);
        peek(3'd4, "R1 shared bit reports 18", 32'(18) << 26);
        // R7 unmapped writes ignored
        step(1'b1, 3'd6, 32'hffff_ffff, '0);
        peek(3'd0, "R7 unmapped write", 32'h0000_0001);
        // R4 clear everything
        clear_all();
        peek(3'd2, "R4 clear all high", 32'h0);
        peek(3'd3, "R4 clear all low", 32'h0);
        peek(3'd4, "R4 clear all vector", 32'h0);

        // random phase compared against the model every cycle
        for (int i = 0; i < 6000; i++) begin
            logic [63:0] ev;
            logic        we;
            logic [2:0]  a;
            logic [31:0] d;
            ev = '0;
            for (int n = 0; n < 64; n++) if (($urandom % 24) == 0) ev[n] = 1'b1;
            we = (($urandom % 3) == 0);
            a  = 3'($urandom % 8);
            d  = $urandom;
            step(we, a, d, ev);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule